// File: doc/BRIEF.md
# Test Packet Generator for a Serial Link Pass-Through Port

This block is a register-driven traffic source for the pass-through port of a serial packet link controller. A host fills a small register bank with a packet kind, destination, transaction tag, hop count, an address/info word, a payload length and a 32-bit seed. It then issues a start command. The generator builds the matching logical-layer request or response and streams it out as 32-bit beats on a valid/ready interface with first-beat and last-beat markers.

Every packet has the same layout. Beat 0 is a header word: `[31:28]` format type, `[27:24]` transaction type, `[23:16]` destination, `[15:8]` transaction tag, `[7:0]` auxiliary byte. Beat 1 is an info word. Any payload words follow. The address register holds packed subfields for doorbell, message and response packets. The running transmit count is stamped into the first payload word of bulk writes.

On the receive side, the block counts every packet that arrives. It also captures the 64-bit data of the most recent maintenance read response. Both values can be read by the host. The block does not generate CRC and never replies to incoming requests.

Top module: `rio_test_pktgen`

## Requirements
- R1: Kind register codes 0..9 select, in order: read request, bulk write, streaming write, maintenance read, maintenance write, port-write, doorbell, message, response without data, response with data. The header format/transaction types are, in the same order: 2/4, 5/4, 6/0, 8/0, 8/1, 8/4, 10/0, 11/0, 13/0, 13/8.
- R2: The first beat carries sop and the last beat carries eop. While tx_valid is high and tx_ready is low, the data and markers hold still. tx_valid drops in the cycle after the last beat is accepted.
- R3: A bulk write carries N payload words (N = size register, where 0 means 1). Word 0 is the transmit packet count. Word 1 is {16'h0, seed[31:16]}. The remaining words equal the seed.
- R4: A streaming write carries N payload words: the transmit packet count followed by seed words.
- R5: Bulk writes use an internal tag instead of the tag register. The first bulk write after reset uses 0x80. The tag steps by one per bulk write and wraps from 0xFF back to 0x80. For read, bulk and streaming writes, the auxiliary byte is N and the info word is the whole address register.
- R6: Maintenance packets put the hop count in the auxiliary byte and {8'h0, addr[23:0]} in the info word. Maintenance write and port-write append one seed word; maintenance read appends none.
- R7: Doorbell and message packets put {16'h0, addr[15:0]} in the info word. The message fields are length [15:12], size [11:8], letter [7:6], mailbox [5:4] and message [3:0]. A message appends one seed word; a doorbell appends none.
- R8: Response packets take their tag from addr[7:0] and put {28'h0, addr[11:8]} (status) in the info word. The with-data variant appends one seed word.
- R9: A start is held pending until both the output-enable and input-enable bits of the control register are set. The packet then goes out with no further command.
- R10: The transmit count starts at 0 and increments once for each packet whose last beat is accepted.
- R11: Every received beat with rx_eop increments the receive count. A received packet whose header has [31:24] = 0x82 stores its next beat in bits 63:32 and the beat after it in bits 31:0 of the response capture.
- R12: A start with a kind code of 10..15, or one issued while a packet is in flight, produces no packet.
- R13: The register offsets are: 0 control (bit0 output enable, bit1 input enable, bit2 start when written), 1 kind, 2 destination, 3 tag, 4 hop, 5 address, 6 size, 7 seed, 8 transmit count, 9 receive count, 10 capture[31:0], 11 capture[63:32]. All of them are readable combinationally on reg_rdata at reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| tx_data | output | 32 | Transmit beat data |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | First receive beat |
| rx_eop | input | 1 | Last receive beat |
| rx_data | input | 32 | Receive beat data |

## Verification
The assertions check the following on every cycle:
- beats hold still under backpressure;
- no beat follows an accepted last beat in the next cycle;
- each header carries a legal format type;
- transmission starts only while both enables are set;
- the transmit count moves only on an accepted last beat.

The packet contents need the bench's scenarios, which compare every beat against expected words. These cover the header fields, packed subfields, stamped count and seed pattern for each kind, and the wrap of the bulk-write tag after 128 packets. The bench also covers the pending start, the ignored starts and the capture of maintenance read responses.

// File: rtl/rio_test_pktgen.sv
module rio_test_pktgen #(
  parameter int CW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic [31:0] tx_data,
  input  logic        rx_valid,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic [31:0] rx_data
);
  localparam logic [3:0] K_NRD = 4'd0, K_NWR = 4'd1, K_SWR = 4'd2, K_MRD = 4'd3,
                         K_MWR = 4'd4, K_MPW = 4'd5, K_DB = 4'd6, K_MSG = 4'd7,
                         K_RSP = 4'd8, K_RSPD = 4'd9;

  logic          out_en, in_en, pend, busy;
  logic [3:0]    kind, kind_q, ftype, ttype;
  logic [7:0]    dest, tid, hop, size, nw_tid, hdr_tid, aux, nw;
  logic [31:0]   addr, seed, info, pay;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [63:0]   mrd;
  logic [1:0]    rx_ph;
  logic [8:0]    idx, npay, p;
  logic          last, fire, go;

  assign nw   = (size == 8'd0) ? 8'd1 : size;
  assign p    = idx - 9'd2;
  assign last = (idx == npay + 9'd1);
  assign fire = busy && tx_ready;
  assign go   = pend && out_en && in_en && !busy;

  always_comb begin
    npay = 9'd0; ftype = 4'd0; ttype = 4'd0; hdr_tid = tid; aux = 8'd0; info = addr;
    case (kind_q)
      K_NRD:  begin ftype = 4'd2;  ttype = 4'd4; aux = nw; end
      K_NWR:  begin ftype = 4'd5;  ttype = 4'd4; aux = nw; npay = {1'b0, nw}; hdr_tid = nw_tid; end
      K_SWR:  begin ftype = 4'd6;  aux = nw; npay = {1'b0, nw}; end
      K_MRD:  begin ftype = 4'd8;  aux = hop; info = {8'h0, addr[23:0]}; end
      K_MWR:  begin ftype = 4'd8;  ttype = 4'd1; aux = hop; info = {8'h0, addr[23:0]}; npay = 9'd1; end
      K_MPW:  begin ftype = 4'd8;  ttype = 4'd4; aux = hop; info = {8'h0, addr[23:0]}; npay = 9'd1; end
      K_DB:   begin ftype = 4'd10; info = {16'h0, addr[15:0]}; end
      K_MSG:  begin ftype = 4'd11; info = {16'h0, addr[15:0]}; npay = 9'd1; end
      K_RSP:  begin ftype = 4'd13; hdr_tid = addr[7:0]; info = {28'h0, addr[11:8]}; end
      default: begin ftype = 4'd13; ttype = 4'd8; hdr_tid = addr[7:0]; info = {28'h0, addr[11:8]}; npay = 9'd1; end
    endcase
  end

  always_comb begin
    pay = seed;
    if (kind_q == K_NWR && p == 9'd0) pay = tx_cnt[31:0];
    else if (kind_q == K_NWR && p == 9'd1) pay = {16'h0, seed[31:16]};
    else if (kind_q == K_SWR && p == 9'd0) pay = tx_cnt[31:0];
  end

  assign tx_valid = busy;
  assign tx_sop   = busy && (idx == 9'd0);
  assign tx_eop   = busy && last;
  assign tx_data  = (idx == 9'd0) ? {ftype, ttype, dest, hdr_tid, aux} :
                    (idx == 9'd1) ? info : pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_en <= 1'b0; in_en <= 1'b0; pend <= 1'b0; busy <= 1'b0;
      kind <= '0; kind_q <= '0; dest <= '0; tid <= '0; hop <= '0; size <= '0;
      addr <= '0; seed <= '0; nw_tid <= 8'h80; tx_cnt <= '0; idx <= '0;
    end else begin
      if (go) begin
        busy <= 1'b1; pend <= 1'b0; idx <= '0; kind_q <= kind;
      end
      if (fire) begin
        if (last) begin
          busy <= 1'b0;
          tx_cnt <= tx_cnt + 1'b1;
          if (kind_q == K_NWR) nw_tid <= (nw_tid == 8'hFF) ? 8'h80 : nw_tid + 8'd1;
        end else idx <= idx + 9'd1;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'd0: begin
            out_en <= reg_wdata[0]; in_en <= reg_wdata[1];
            if (reg_wdata[2] && !busy && !pend && kind <= K_RSPD) pend <= 1'b1;
          end
          4'd1: kind <= reg_wdata[3:0];
          4'd2: dest <= reg_wdata[7:0];
          4'd3: tid  <= reg_wdata[7:0];
          4'd4: hop  <= reg_wdata[7:0];
          4'd5: addr <= reg_wdata;
          4'd6: size <= reg_wdata[7:0];
          4'd7: seed <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0; mrd <= '0; rx_ph <= 2'd0;
    end else if (rx_valid) begin
      if (rx_sop) rx_ph <= (rx_data[31:24] == 8'h82) ? 2'd1 : 2'd0;
      else if (rx_ph == 2'd1) begin mrd[63:32] <= rx_data; rx_ph <= 2'd2; end
      else if (rx_ph == 2'd2) begin mrd[31:0] <= rx_data; rx_ph <= 2'd0; end
      if (rx_eop) rx_cnt <= rx_cnt + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:  reg_rdata = {30'h0, in_en, out_en};
      4'd1:  reg_rdata = {28'h0, kind};
      4'd2:  reg_rdata = {24'h0, dest};
      4'd3:  reg_rdata = {24'h0, tid};
      4'd4:  reg_rdata = {24'h0, hop};
      4'd5:  reg_rdata = addr;
      4'd6:  reg_rdata = {24'h0, size};
      4'd7:  reg_rdata = seed;
      4'd8:  reg_rdata = tx_cnt[31:0];
      4'd9:  reg_rdata = rx_cnt[31:0];
      4'd10: reg_rdata = mrd[31:0];
      4'd11: reg_rdata = mrd[63:32];
      default: reg_rdata = 32'h0;
    endcase
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

  a_r1_ftype: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> (tx_data[31:28] inside {4'd2, 4'd5, 4'd6, 4'd8, 4'd10, 4'd11, 4'd13}));

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (out_en && in_en));

  a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready && tx_eop) |=> $stable(tx_cnt));
endmodule

// File: tb/test_rio_test_pktgen.sv
module test_rio_test_pktgen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid, tx_ready = 1'b0, tx_sop, tx_eop;
  logic [31:0] tx_data;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [31:0] rx_data = '0;

  always #2 clk = ~clk;

  rio_test_pktgen i_rio_test_pktgen (.*);

  int checks = 0, fails = 0, cyc = 0, pkts = 0;
  logic [7:0] ntid = 8'h80;
  logic [31:0] got [64];
  bit gsop [64], geop [64];
  int nb;

  localparam logic [7:0] DEST = 8'h5A, TAG = 8'h33, HOP = 8'h07;
  // {kind, size, addr, seed}
  localparam logic [75:0] VEC [12] = '{
    {4'd0, 8'd4, 32'h1000_0040, 32'hDEAD_BEEF},
    {4'd1, 8'd5, 32'h2000_0080, 32'hCAFE_F00D},
    {4'd1, 8'd0, 32'h2000_0100, 32'h1234_5678},
    {4'd2, 8'd3, 32'h3000_0000, 32'hA5A5_5A5A},
    {4'd3, 8'd1, 32'hAB12_3456, 32'h0},
    {4'd4, 8'd1, 32'hFF00_0010, 32'h0BAD_CAFE},
    {4'd5, 8'd1, 32'h77AB_CDEF, 32'h1111_2222},
    {4'd6, 8'd1, 32'hFFFF_BEEF, 32'h0},
    {4'd7, 8'd1, 32'h1234_A7D5, 32'h9999_8888},
    {4'd8, 8'd1, 32'hFFFF_F3C4, 32'h0},
    {4'd9, 8'd1, 32'h0000_0A11, 32'h4444_3333},
    {4'd2, 8'd1, 32'h0, 32'h5555_6666}
  };

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic collect();
    nb = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      cyc++;
      tx_ready = (cyc % 3) != 2;
      if (tx_valid && tx_ready) begin
        got[nb] = tx_data; gsop[nb] = tx_sop; geop[nb] = tx_eop; nb++;
        if (tx_eop) break;
      end
    end
    @(negedge clk); tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] wn(logic [7:0] sz);
    return (sz == 0) ? 8'd1 : sz;
  endfunction

  function automatic int exp_n(logic [3:0] k, logic [7:0] sz);
    case (k)
      4'd1, 4'd2: return 2 + int'(wn(sz));
      4'd4, 4'd5, 4'd7, 4'd9: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] exp_w(logic [3:0] k, int j, logic [7:0] sz,
                                        logic [31:0] a, logic [31:0] s, logic [31:0] c, logic [7:0] nt);
    logic [3:0] ft, tt; logic [7:0] tg, ax;
    if (j == 0) begin
      tg = TAG; ax = 8'h0;
      case (k)
        4'd0: begin ft = 2; tt = 4; ax = wn(sz); end
        4'd1: begin ft = 5; tt = 4; ax = wn(sz); tg = nt; end
        4'd2: begin ft = 6; tt = 0; ax = wn(sz); end
        4'd3: begin ft = 8; tt = 0; ax = HOP; end
        4'd4: begin ft = 8; tt = 1; ax = HOP; end
        4'd5: begin ft = 8; tt = 4; ax = HOP; end
        4'd6: begin ft = 10; tt = 0; end
        4'd7: begin ft = 11; tt = 0; end
        4'd8: begin ft = 13; tt = 0; tg = a[7:0]; end
        default: begin ft = 13; tt = 8; tg = a[7:0]; end
      endcase
      return {ft, tt, DEST, tg, ax};
    end
    if (j == 1) begin
      case (k)
        4'd0, 4'd1, 4'd2: return a;
        4'd3, 4'd4, 4'd5: return {8'h0, a[23:0]};
        4'd6, 4'd7: return {16'h0, a[15:0]};
        default: return {28'h0, a[11:8]};
      endcase
    end
    if ((k == 4'd1 || k == 4'd2) && j == 2) return c;
    if (k == 4'd1 && j == 3) return {16'h0, s[31:16]};
    return s;
  endfunction

  function automatic string rq(logic [3:0] k);
    case (k)
      4'd0: return "R1";  4'd1: return "R3"; 4'd2: return "R4";
      4'd3, 4'd4, 4'd5: return "R6"; 4'd6, 4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_pkt(logic [3:0] k, logic [7:0] sz, logic [31:0] a, logic [31:0] s);
    int en;
    en = exp_n(k, sz);
    chk(nb == en, "R2 beat count", 64'(nb), 64'(en));
    for (int j = 0; j < nb && j < en; j++) begin
      logic [31:0] e;
      e = exp_w(k, j, sz, a, s, 32'(pkts), ntid);
      chk(got[j] == e && gsop[j] == (j == 0) && geop[j] == (j == en - 1),
          $sformatf("%s/R2 beat %0d", rq(k), j), {got[j], 30'h0, gsop[j], geop[j]},
          {e, 30'h0, j == 0, j == en - 1});
    end
    pkts++;
    if (k == 4'd1) ntid = (ntid == 8'hFF) ? 8'h80 : ntid + 8'd1;
  endtask

  task automatic send(logic [3:0] k, logic [7:0] sz, logic [31:0] a, logic [31:0] s);
    wr(4'd1, {28'h0, k}); wr(4'd6, {24'h0, sz}); wr(4'd5, a); wr(4'd7, s);
    wr(4'd0, 32'h7);
    collect();
    check_pkt(k, sz, a, s);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "R2 reset valid", 64'(tx_valid), 0);
    rd(4'd8, v); chk(v == 0, "R10 reset tx count", 64'(v), 0);
    rd(4'd9, v); chk(v == 0, "R11 reset rx count", 64'(v), 0);
    wr(4'd2, {24'h0, DEST}); wr(4'd3, {24'h0, TAG}); wr(4'd4, {24'h0, HOP});
    rd(4'd2, v); chk(v == 32'(DEST), "R13 dest readback", 64'(v), 64'(DEST));

    // R9: start held while enables clear
    wr(4'd1, 32'd6); wr(4'd5, 32'h0000_4321);
    wr(4'd0, 32'h4);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_valid) seen = 1; end
    chk(!seen, "R9 held while disabled", 64'(seen), 0);
    wr(4'd0, 32'h1);
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (tx_valid) seen = 1; end
    chk(!seen, "R9 held with one enable", 64'(seen), 0);
    wr(4'd0, 32'h3);
    collect();
    check_pkt(4'd6, 8'd1, 32'h0000_4321, 32'h0);

    // table of packet vectors
    for (int t = 0; t < 12; t++) begin
      logic [75:0] e;
      e = VEC[t];
      send(e[75:72], e[71:64], e[63:32], e[31:0]);
    end
    rd(4'd8, v); chk(v == 32'(pkts), "R10 tx count", 64'(v), 64'(pkts));

    // R12: illegal kind and start while busy
    wr(4'd1, 32'd12); wr(4'd0, 32'h7);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_valid) seen = 1; end
    chk(!seen, "R12 illegal kind ignored", 64'(seen), 0);
    wr(4'd1, 32'd2); wr(4'd6, 32'd20); wr(4'd7, 32'h0F0F_0F0F);
    wr(4'd0, 32'h7);
    wr(4'd0, 32'h7);
    collect();
    check_pkt(4'd2, 8'd20, 32'h0, 32'h0F0F_0F0F);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_valid) seen = 1; end
    chk(!seen, "R12 start while busy ignored", 64'(seen), 0);

    // R5: bulk-write tag wrap
    for (int i = 0; i < 130; i++) begin
      logic [7:0] et;
      et = ntid;
      wr(4'd1, 32'd1); wr(4'd6, 32'd1); wr(4'd0, 32'h7);
      collect();
      chk(nb > 0 && got[0][15:8] == et, "R5 tag sequence", 64'(got[0][15:8]), 64'(et));
      pkts++;
      ntid = (ntid == 8'hFF) ? 8'h80 : ntid + 8'd1;
    end
    rd(4'd8, v); chk(v == 32'(pkts), "R10 tx count after wrap", 64'(v), 64'(pkts));

    // R11: receive side
    @(negedge clk); rx_valid = 1; rx_sop = 1; rx_eop = 0; rx_data = 32'h8200_0000;
    @(negedge clk); rx_sop = 0; rx_data = 32'hAAAA_BBBB;
    @(negedge clk); rx_eop = 1; rx_data = 32'hCCCC_DDDD;
    @(negedge clk); rx_sop = 1; rx_eop = 0; rx_data = 32'h8000_0000;
    @(negedge clk); rx_sop = 0; rx_data = 32'h1;
    @(negedge clk); rx_eop = 1; rx_data = 32'h2;
    @(negedge clk); rx_valid = 0; rx_eop = 0;
    rd(4'd9, v);  chk(v == 2, "R11 rx count", 64'(v), 2);
    rd(4'd11, v); chk(v == 32'hAAAA_BBBB, "R11 capture high", 64'(v), 64'hAAAA_BBBB);
    rd(4'd10, v); chk(v == 32'hCCCC_DDDD, "R11 capture low", 64'(v), 64'hCCCC_DDDD);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule